// File: doc/BRIEF.md
# Ping-Pong Pixel Line Buffer

This block sits between a video source that delivers pixels at pixel-clock rate and a link-side consumer that can drain pixels up to twice as fast. Two line memories are used in alternation. The writer fills one while the reader empties the other, and each line is closed by a horizontal sync pulse. Because the reader can run faster than the writer, the link gains idle time in which other traffic can be interleaved.

A line can be read only after its sync pulse has committed it, so the reader never sees a partly written line. The writer only ever targets a bank that holds no unread line, so the two sides never touch the same bank. Sync pulses are not stored. They are forwarded one cycle late as timing markers. If a sync pulse arrives while the other bank still holds an unread line, the new line is dropped and an overflow pulse is raised. An empty line is ignored. An over-long line is cut to the bank size and an error pulse is raised.

Everything runs on one clock. The link-side rate is set by a read enable and a valid/ready handshake.

Top module: `pp_line_buf`

## Requirements
- R1: There are two banks. Each holds up to MAX_LEN pixels (default 1024) of PIX_W bits (default 24). The pixels of a committed line are read out in the order they were written.
- R2: `rd_valid_o` stays low for a line until that line's `hsync_i` has been sampled. The earliest cycle it can rise is the cycle after that sample.
- R3: The writer never writes a bank that holds an unread line. This means writing the next line runs concurrently with reading the previous one without corrupting it.
- R4: A pixel is consumed only in a cycle with `rd_valid_o && rd_ready_i`. While `rd_ready_i` is low, the presented pixel and its position do not change.
- R5: `rd_last_o` is high together with `rd_valid_o` on the final pixel of each line only. Consuming that pixel frees its bank.
- R6: While `rd_en_i` is low, `rd_valid_o` is low and nothing is consumed.
- R7: An `hsync_i` that closes a non-empty line while the other bank still holds an unread line drops the new line. `ovf_o` is then high for exactly the next cycle.
- R8: An `hsync_i` with no pixels written since the previous one has no effect. Nothing is committed, no pulse is raised, and the bank choice does not change.
- R9: A line with more than MAX_LEN pixels keeps its first MAX_LEN pixels and discards the rest. `len_err_o` is then high for the cycle after its `hsync_i`.
- R10: `hsync_o` equals `hsync_i` delayed by one cycle. A pixel presented in the same cycle as `hsync_i` is discarded.
- R11: After reset, `rd_valid_o`, `rd_last_o`, `ovf_o`, `len_err_o` and `hsync_o` are low and both banks are empty.
- R12: The reader can accept a pixel on every cycle, which is twice the pixel rate, while the writer stores the next line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| pix_vld_i | input | 1 | writer pixel strobe |
| pix_data_i | input | PIX_W | writer pixel value |
| hsync_i | input | 1 | end-of-line sync pulse |
| rd_en_i | input | 1 | link-side read-rate enable |
| rd_ready_i | input | 1 | link side accepts the pixel |
| rd_valid_o | output | 1 | a pixel is presented |
| rd_data_o | output | PIX_W | presented pixel |
| rd_last_o | output | 1 | presented pixel ends its line |
| hsync_o | output | 1 | forwarded sync marker |
| ovf_o | output | 1 | line dropped, one-cycle pulse |
| len_err_o | output | 1 | line clamped, one-cycle pulse |

## Verification
The read outputs are combinational from the bank state. A commit made on the edge that samples `hsync_i` therefore shows up as `rd_valid_o` in the very next cycle. `hsync_o`, `ovf_o` and `len_err_o` are registered, so each is due exactly one cycle after the `hsync_i` that caused it. The bench's reference model holds the pending line as a queue of pixels. It predicts each output for the current cycle from the state left by earlier edges. It compares the prediction with the DUT a quarter period after the falling edge, when the inputs have settled. Only then does it apply the current inputs to its own state, so every prediction lines up with the register the DUT updates on the following rising edge.

// File: rtl/pp_lb_pkg.sv
package pp_lb_pkg;
  typedef enum logic {BANK0 = 1'b0, BANK1 = 1'b1} bank_e;

  function automatic bank_e other_bank(bank_e b);
    return bank_e'(~b);
  endfunction
endpackage

// File: rtl/pp_lb_wr_ctrl.sv
module pp_lb_wr_ctrl
  import pp_lb_pkg::*;
#(
  parameter int MAX_LEN = 1024,
  localparam int AW = $clog2(MAX_LEN),
  localparam int LW = $clog2(MAX_LEN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pix_vld_i,
  input  logic          hsync_i,
  input  logic [1:0]    full_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output bank_e         wsel_o,
  output logic          commit_o,
  output logic [LW-1:0] commit_len_o,
  output logic          ovf_o,
  output logic          len_err_o
);
  localparam logic [LW-1:0] MaxL = LW'(MAX_LEN);

  logic [LW-1:0] cnt_q;
  logic          over_q, ovf_q, lerr_q;
  bank_e         wsel_q;
  logic          line_nz, other_full, drop;

  assign line_nz    = (cnt_q != '0);
  assign other_full = full_i[other_bank(wsel_q)];
  assign commit_o   = hsync_i && line_nz && !other_full;
  assign drop       = hsync_i && line_nz && other_full;
  // sync cycle carries no pixel
  assign we_o         = pix_vld_i && !hsync_i && (cnt_q < MaxL);
  assign waddr_o      = cnt_q[AW-1:0];
  assign wsel_o       = wsel_q;
  assign commit_len_o = cnt_q;
  assign ovf_o        = ovf_q;
  assign len_err_o    = lerr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      over_q <= 1'b0;
      wsel_q <= BANK0;
      ovf_q  <= 1'b0;
      lerr_q <= 1'b0;
    end else begin
      ovf_q  <= drop;
      lerr_q <= hsync_i && over_q;
      if (hsync_i) begin
        cnt_q  <= '0;
        over_q <= 1'b0;
        if (commit_o) wsel_q <= other_bank(wsel_q);
      end else if (pix_vld_i) begin
        if (cnt_q < MaxL) cnt_q <= cnt_q + LW'(1);
        else              over_q <= 1'b1;
      end
    end
  end

  AST_OVF_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> !ovf_o); // R7
  AST_EMPTY_LINE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hsync_i && cnt_q == '0) |=> (!ovf_o && !len_err_o)); // R8
  AST_EMPTY_LINE_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hsync_i && cnt_q == '0) |=> $stable(wsel_q)); // R8
  AST_LEN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> (commit_len_o != '0 && commit_len_o <= MaxL)); // R9
endmodule

// File: rtl/pp_lb_rd_ctrl.sv
module pp_lb_rd_ctrl
  import pp_lb_pkg::*;
#(
  parameter int MAX_LEN = 1024,
  localparam int AW = $clog2(MAX_LEN),
  localparam int LW = $clog2(MAX_LEN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    full_i,
  input  logic [LW-1:0] len0_i,
  input  logic [LW-1:0] len1_i,
  input  logic          rd_en_i,
  input  logic          rd_ready_i,
  output bank_e         rsel_o,
  output logic [AW-1:0] raddr_o,
  output logic          valid_o,
  output logic          last_o,
  output logic          done_o
);
  bank_e         rsel_q;
  logic [AW-1:0] ptr_q;
  logic [LW-1:0] cur_len;
  logic          fire;

  assign cur_len = (rsel_q == BANK1) ? len1_i : len0_i;
  assign valid_o = rd_en_i && full_i[rsel_q];
  assign last_o  = valid_o && ((LW'(ptr_q) + LW'(1)) == cur_len);
  assign fire    = valid_o && rd_ready_i;
  assign done_o  = fire && last_o;
  assign rsel_o  = rsel_q;
  assign raddr_o = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsel_q <= BANK0;
      ptr_q  <= '0;
    end else if (done_o) begin
      rsel_q <= other_bank(rsel_q);
      ptr_q  <= '0;
    end else if (fire) begin
      ptr_q  <= ptr_q + AW'(1);
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !rd_ready_i) |=> ($stable(ptr_q) && $stable(rsel_q))); // R4
  AST_NO_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(ptr_q)); // R6
endmodule

// File: rtl/pp_lb_mem.sv
module pp_lb_mem
  import pp_lb_pkg::*;
#(
  parameter int PIX_W = 24,
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  bank_e            wsel_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [PIX_W-1:0] wdata_i,
  input  bank_e            rsel_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [PIX_W-1:0] rdata_o
);
  logic [PIX_W-1:0] bank_rd [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [PIX_W-1:0] mem_q [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && wsel_i == bank_e'(b)) mem_q[waddr_i] <= wdata_i;
    end
    assign bank_rd[b] = mem_q[raddr_i];
  end

  assign rdata_o = bank_rd[rsel_i];
endmodule

// File: rtl/pp_line_buf.sv
module pp_line_buf
  import pp_lb_pkg::*;
#(
  parameter int PIX_W   = 24,
  parameter int MAX_LEN = 1024,
  localparam int AW = $clog2(MAX_LEN),
  localparam int LW = $clog2(MAX_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pix_vld_i,
  input  logic [PIX_W-1:0] pix_data_i,
  input  logic             hsync_i,
  input  logic             rd_en_i,
  input  logic             rd_ready_i,
  output logic             rd_valid_o,
  output logic [PIX_W-1:0] rd_data_o,
  output logic             rd_last_o,
  output logic             hsync_o,
  output logic             ovf_o,
  output logic             len_err_o
);
  logic [1:0]    full_q;
  logic [LW-1:0] len_q [2];
  logic          hs_q;

  logic          we, commit, done;
  logic [AW-1:0] waddr, raddr;
  logic [LW-1:0] commit_len;
  bank_e         wsel, rsel;

  pp_lb_wr_ctrl #(.MAX_LEN(MAX_LEN)) u_wr (
    .clk_i, .rst_ni, .pix_vld_i, .hsync_i,
    .full_i(full_q), .we_o(we), .waddr_o(waddr), .wsel_o(wsel),
    .commit_o(commit), .commit_len_o(commit_len),
    .ovf_o, .len_err_o
  );

  pp_lb_rd_ctrl #(.MAX_LEN(MAX_LEN)) u_rd (
    .clk_i, .rst_ni, .full_i(full_q),
    .len0_i(len_q[0]), .len1_i(len_q[1]),
    .rd_en_i, .rd_ready_i,
    .rsel_o(rsel), .raddr_o(raddr),
    .valid_o(rd_valid_o), .last_o(rd_last_o), .done_o(done)
  );

  pp_lb_mem #(.PIX_W(PIX_W), .DEPTH(MAX_LEN)) u_mem (
    .clk_i, .we_i(we), .wsel_i(wsel), .waddr_i(waddr), .wdata_i(pix_data_i),
    .rsel_i(rsel), .raddr_i(raddr), .rdata_o(rd_data_o)
  );

  // commit and release always hit different banks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q   <= '0;
      len_q[0] <= '0;
      len_q[1] <= '0;
      hs_q     <= 1'b0;
    end else begin
      hs_q <= hsync_i;
      if (commit) begin
        full_q[wsel] <= 1'b1;
        len_q[wsel]  <= commit_len;
      end
      if (done) full_q[rsel] <= 1'b0;
    end
  end

  assign hsync_o = hs_q;

  AST_WR_BANK_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_q[wsel]); // R3
  AST_LAST_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && rd_ready_i && rd_last_o) |=> !full_q[$past(rsel)]); // R5
  AST_VALID_NEEDS_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_valid_o) |-> (|full_q)); // R2
  AST_HS_FORWARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hsync_i |=> hsync_o); // R10
endmodule

// File: tb/sim_pp_line_buf.sv
module sim_pp_line_buf;
  localparam int CLK_PERIOD = 10;
  localparam int PW   = 24;
  localparam int MLEN = 16;
  localparam int WDOG = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pix_vld = 1'b0;
  logic [PW-1:0] pix_data = '0;
  logic          hsync = 1'b0;
  logic          rd_en = 1'b0;
  logic          rd_ready = 1'b0;
  logic          rd_valid, rd_last, hs_out, ovf, lerr;
  logic [PW-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int ready_mode = 0;   // 0 always, 1 pseudo-random
  int fires = 0;
  int b2b_fires = 0;
  bit prev_fire = 0;
  bit done_flag = 0;

  // reference model state
  logic [PW-1:0] pend_q [$];
  logic [PW-1:0] cur_q [$];
  bit m_over = 0, m_ovf = 0, m_lerr = 0, m_hs = 0;
  logic [PW-1:0] pix_seq = 24'h100;

  pp_line_buf #(.PIX_W(PW), .MAX_LEN(MLEN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pix_vld_i(pix_vld), .pix_data_i(pix_data),
    .hsync_i(hsync), .rd_en_i(rd_en), .rd_ready_i(rd_ready),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .rd_last_o(rd_last),
    .hsync_o(hs_out), .ovf_o(ovf), .len_err_o(lerr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // ready driver
  always @(negedge clk) begin
    if (ready_mode == 1) rd_ready <= ($urandom_range(0, 2) != 0);
    else                 rd_ready <= 1'b1;
  end

  // per-cycle compare and model update, a quarter period after the falling edge
  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    cyc++;
    if (cyc > WDOG) begin
      errors++;
      $display("FAIL watchdog expired act=%0d exp=%0d", cyc, WDOG);
      finish_run();
    end
    if (rst_n) begin
      bit ev, el, fire_now;
      ev = rd_en && (pend_q.size() != 0);
      el = ev && (pend_q.size() == 1);
      chk(rd_valid == ev, rd_en ? "R2 valid" : "R6 valid", int'(rd_valid), int'(ev));
      if (ev) begin
        chk(rd_data == pend_q[0], "R1 data", int'(rd_data), int'(pend_q[0]));
        chk(rd_last == el, "R5 last", int'(rd_last), int'(el));
      end
      chk(ovf == m_ovf, "R7 ovf", int'(ovf), int'(m_ovf));
      chk(lerr == m_lerr, "R9 len_err", int'(lerr), int'(m_lerr));
      chk(hs_out == m_hs, "R10 hsync_o", int'(hs_out), int'(m_hs));
      fire_now = ev && rd_ready;
      if (fire_now) begin
        fires++;
        if (prev_fire) b2b_fires++;
      end
      prev_fire = fire_now;
      // write side sees pending state before this edge's release
      m_ovf = 0; m_lerr = 0; m_hs = hsync;
      if (hsync) begin
        if (cur_q.size() != 0) begin
          m_lerr = m_over;
          if (pend_q.size() != 0) m_ovf = 1;
          else pend_q = cur_q;
        end
        cur_q = {};
        m_over = 0;
      end else if (pix_vld) begin
        if (cur_q.size() < MLEN) cur_q.push_back(pix_data);
        else m_over = 1;
      end
      if (fire_now) void'(pend_q.pop_front());
    end
  end

  task automatic send_line(input int n, input int gap, input bit pix_on_hs);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pix_vld = 1'b1; pix_data = pix_seq; pix_seq = pix_seq + 1;
      for (int g = 1; g < gap; g++) begin
        @(negedge clk);
        pix_vld = 1'b0;
      end
    end
    @(negedge clk);
    hsync = 1'b1;
    pix_vld = pix_on_hs;
    pix_data = 24'hDEAD00;
    @(negedge clk);
    hsync = 1'b0; pix_vld = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 500 && pend_q.size() != 0; i++) @(negedge clk);
    idle(2);
  endtask

  initial begin
    int e0, f0;
    idle(3);
    // R11 reset state
    chk(rd_valid == 0 && rd_last == 0, "R11 read outputs", int'({rd_valid, rd_last}), 0);
    chk(ovf == 0 && lerr == 0 && hs_out == 0, "R11 pulses", int'({ovf, lerr, hs_out}), 0);
    @(negedge clk); rst_n = 1'b1; rd_en = 1'b1;
    idle(2);
    chk(rd_valid == 0, "R11 empty after reset", int'(rd_valid), 0);

    // R1 R2 R5 basic line at pixel rate, reader always ready
    send_line(5, 2, 0);
    drain();
    // R10 pixel presented on the sync cycle is discarded
    send_line(3, 1, 1);
    drain();

    // R12 R3 back-to-back lines: reader at full rate while writer fills next bank
    e0 = errors; b2b_fires = 0;
    for (int k = 0; k < 4; k++) send_line(6, 2, 0);
    drain();
    chk(errors == e0, "R3 concurrent lines intact", errors - e0, 0);
    chk(b2b_fires > 0, "R12 back-to-back reads", b2b_fires, 1);

    // R4 stalled reader
    ready_mode = 1;
    e0 = errors;
    for (int k = 0; k < 3; k++) send_line(7, 2, 0);
    drain();
    chk(errors == e0, "R4 stall keeps order", errors - e0, 0);
    ready_mode = 0;

    // R6 R7 read disabled: second line overflows and is dropped
    rd_en = 1'b0;
    send_line(4, 2, 0);
    idle(3);
    chk(rd_valid == 0, "R6 disabled valid", int'(rd_valid), 0);
    send_line(4, 2, 0);
    idle(2);
    rd_en = 1'b1;
    f0 = fires;
    drain();
    chk(fires - f0 == 4, "R7 only first line read", fires - f0, 4);

    // R8 empty line ignored
    @(negedge clk); hsync = 1'b1;
    @(negedge clk); hsync = 1'b0;
    idle(3);
    chk(rd_valid == 0 && ovf == 0, "R8 empty line", int'({rd_valid, ovf}), 0);
    send_line(2, 2, 0);
    drain();

    // R9 over-long line clamped
    f0 = fires;
    send_line(MLEN + 4, 1, 0);
    drain();
    chk(fires - f0 == MLEN, "R9 clamped length", fires - f0, MLEN);

    // R5 single-pixel line
    send_line(1, 2, 0);
    drain();
    chk(pend_q.size() == 0 && rd_valid == 0, "R5 bank freed", int'(rd_valid), 0);

    idle(4);
    finish_run();
  end
endmodule